// File: doc/BRIEF.md
# ADC Master Serial Readout Controller

This block shifts a 14-bit result from a successive-approximation converter out over a three-wire serial link. The block is the link master. It makes its own bit clock (SDCLK) and a frame-valid strobe (SYNC), and it drives the data line (SDOUT). A conversion begins on a one-cycle pulse on `conv_start`. BUSY then rises, and the converter core hands over its result on a valid/ready port.

There are two read timings. In read-during-convert mode, a start pulse launches a frame that carries the *previous* result while the new conversion runs. BUSY falls as soon as the new result is taken. In this mode the bit clock runs fast for the upper ten bits and slower for the last four. In read-after-convert mode, the frame carries the *new* result and starts right after it is taken. BUSY stays high until the frame has ended. A 2-bit divider input picks one of four fixed bit-clock rates. Either SDCLK or SYNC can be inverted. A serial-enable input parks all three serial pins low.

The result port follows valid/ready rules. `res_ready` is high only while a conversion is pending. The source holds `res_data` steady with `res_valid` until the cycle in which both are high. The block never stalls a frame for lack of a result. A `res_valid` pulse outside the ready window is dropped.

Top module: `adc_serial_master`

## Requirements
- R1: After reset, `busy` and `res_ready` are low, SDOUT is low, SDCLK rests at its idle level (low when `inv_clk`=0), and SYNC is inactive (low when `inv_sync`=0).
- R2: Each frame carries exactly 14 bits, most significant first, with exactly 14 SDCLK pulses. SDCLK does not pulse outside a frame.
- R3: SDOUT changes only at the falling edge of the non-inverted clock. It holds its value through each whole high phase, so the host may sample on either edge.
- R4: SYNC becomes active one system clock before the first SDCLK edge of a frame. It stays active until one system clock after the last falling edge. A frame therefore spans 2 + the sum of all half-periods, in system clocks.
- R5: With `inv_clk`=1, the SDCLK pin is the logical inverse of the non-inverted waveform, including its idle level. With `inv_sync`=1, the same holds for SYNC.
- R6: In read-during mode (`rd_during`=1), an accepted start launches a frame holding the last accepted result, and `busy` falls in the cycle after the new result is taken. The first conversion after reset emits no frame.
- R7: In read-during mode, bits 13 down to 4 use a half-period of 2 system clocks and bits 3 down to 0 use 4, so the frame spans 74 clocks.
- R8: In read-after mode (`rd_during`=0), the frame carries the result just taken and starts in the next cycle. `busy` stays high until it falls in the same cycle as SYNC goes inactive.
- R9: In read-after mode, every half-period is 2^(`div_sel`+1) system clocks (2, 4, 8 or 16 for `div_sel` 0 to 3).
- R10: A `conv_start` pulse is ignored while `busy` is high or while a frame is being shifted.
- R11: `res_ready` is high exactly while a conversion awaits its result. A result is taken on `res_valid` && `res_ready`, and a `res_valid` with `res_ready` low has no effect.
- R12: With `ser_en`=0, no frame is launched and SDCLK, SDOUT and SYNC stay low whatever the polarity inputs. Results are still taken and become the previous result for later frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial output enable |
| rd_during | input | 1 | 1: read-during-convert, 0: read-after-convert |
| div_sel | input | 2 | Bit-clock rate select for read-after mode |
| inv_clk | input | 1 | Invert SDCLK |
| inv_sync | input | 1 | Invert SYNC |
| conv_start | input | 1 | Conversion start pulse |
| res_data | input | 14 | Conversion result |
| res_valid | input | 1 | Result valid |
| res_ready | output | 1 | Result can be taken |
| busy | output | 1 | Conversion (and, in read-after mode, readout) in progress |
| sdclk | output | 1 | Serial bit clock |
| sdout | output | 1 | Serial data, MSB first |
| sync | output | 1 | Frame-valid strobe |

## Verification
In read-during mode, a frame of the old result runs while a new conversion may end or a new start may arrive. So result acceptance, BUSY release and a fresh start request all overlap with a live frame. The bench feeds a result two cycles into a running frame. It then pulses the start input while that frame is still shifting, and checks three things: BUSY stays low, `res_ready` stays low, and exactly one frame with the expected word is seen. In read-after mode, a second start pulse is placed inside the conversion window. The BUSY width, measured from rise to fall, must match the formula for the chosen divider.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_LEAD,
    SH_HIGH,
    SH_LOW,
    SH_TAIL
  } sh_state_e;

endpackage

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter
  import adc_ser_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int DIV_W     = 2,
  parameter int FAST_HALF = 2,
  parameter int SLOW_HALF = 4,
  parameter int SLOW_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fast_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sclk_o,
  output logic              sdout_o,
  output logic              sync_o,
  output logic              active_o,
  output logic              done_o
);

  localparam int MAX_FIX  = 2 << ((1 << DIV_W) - 1);
  localparam int MAX_HALF = (MAX_FIX > SLOW_HALF) ? MAX_FIX : SLOW_HALF;
  localparam int CNT_W    = (MAX_HALF > 2) ? $clog2(MAX_HALF) : 1;
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int PCNT_W   = $clog2(DATA_W + 1);

  sh_state_e         state_q;
  logic [DATA_W-1:0] sreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              fast_q;
  logic [DIV_W-1:0]  div_q;

  // half-period minus one for the bit at position idx (0 = MSB)
  function automatic logic [CNT_W-1:0] half_m1(input logic fast,
                                               input logic [DIV_W-1:0] div,
                                               input logic [IDX_W-1:0] idx);
    int h;
    if (fast) h = (int'(idx) >= DATA_W - SLOW_BITS) ? SLOW_HALF : FAST_HALF;
    else      h = 2 << div;
    return CNT_W'(h - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      sreg_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      fast_q  <= 1'b0;
      div_q   <= '0;
    end else begin
      case (state_q)
        SH_IDLE: if (start_i) begin
          state_q <= SH_LEAD;
          sreg_q  <= data_i;
          idx_q   <= '0;
          fast_q  <= fast_i;
          div_q   <= div_i;
        end
        SH_LEAD: begin
          state_q <= SH_HIGH;
          cnt_q   <= half_m1(fast_q, div_q, idx_q);
        end
        SH_HIGH: begin
          if (cnt_q == '0) begin
            state_q <= SH_LOW;
            cnt_q   <= half_m1(fast_q, div_q, idx_q);
            sreg_q  <= {sreg_q[DATA_W-2:0], 1'b0};
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SH_LOW: begin
          if (cnt_q == '0) begin
            if (idx_q == IDX_W'(DATA_W - 1)) begin
              state_q <= SH_TAIL;
            end else begin
              state_q <= SH_HIGH;
              idx_q   <= idx_q + 1'b1;
              cnt_q   <= half_m1(fast_q, div_q, idx_q + 1'b1);
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SH_TAIL: state_q <= SH_IDLE;
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign sclk_o   = (state_q == SH_HIGH);
  assign sync_o   = (state_q != SH_IDLE);
  assign sdout_o  = sync_o & sreg_q[DATA_W-1];
  assign active_o = (state_q != SH_IDLE);
  assign done_o   = (state_q == SH_TAIL);

  // checker: count clock pulses in the current frame
  logic              sclk_prev_q;
  logic [PCNT_W-1:0] pulses_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      pulses_q    <= '0;
    end else begin
      sclk_prev_q <= sclk_o;
      if (state_q == SH_IDLE)        pulses_q <= '0;
      else if (sclk_o && !sclk_prev_q) pulses_q <= pulses_q + 1'b1;
    end
  end

  p_pulse_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pulses_q == PCNT_W'(DATA_W)));

  p_sdout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && sclk_prev_q) |-> $stable(sdout_o));

  p_clk_in_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $past(sync_o));

  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !active_o);

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start_i,
  input  logic              rd_during_i,
  input  logic              ser_en_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              res_valid_i,
  output logic              res_ready_o,
  output logic              busy_o,
  input  logic              frame_active_i,
  input  logic              frame_done_i,
  output logic              launch_o,
  output logic              launch_fast_o,
  output logic [DATA_W-1:0] launch_data_o
);

  logic              conv_q;
  logic              hold_q;
  logic              mode_q;
  logic              have_prev_q;
  logic [DATA_W-1:0] prev_q;

  logic start_ok, accept, launch_during, launch_after;

  assign busy_o        = conv_q | hold_q;
  assign res_ready_o   = conv_q;
  assign start_ok      = conv_start_i & ~busy_o & ~frame_active_i;
  assign accept        = res_valid_i & conv_q;
  assign launch_during = start_ok & rd_during_i & have_prev_q & ser_en_i;
  assign launch_after  = accept & ~mode_q & ser_en_i;

  assign launch_o      = launch_during | launch_after;
  assign launch_fast_o = launch_during;
  assign launch_data_o = launch_during ? prev_q : res_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q      <= 1'b0;
      hold_q      <= 1'b0;
      mode_q      <= 1'b0;
      have_prev_q <= 1'b0;
      prev_q      <= '0;
    end else begin
      if (start_ok) begin
        conv_q <= 1'b1;
        mode_q <= rd_during_i;
      end else if (accept) begin
        conv_q <= 1'b0;
      end
      if (accept) begin
        prev_q      <= res_data_i;
        have_prev_q <= 1'b1;
      end
      if (launch_after)      hold_q <= 1'b1;
      else if (frame_done_i) hold_q <= 1'b0;
    end
  end

  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_q) |=> !busy_o);

  p_hold_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> frame_active_i);

  p_take_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !res_ready_o);

endmodule

// File: rtl/adc_pin_drive.sv
module adc_pin_drive (
  input  logic ser_en_i,
  input  logic inv_clk_i,
  input  logic inv_sync_i,
  input  logic sclk_i,
  input  logic sdout_i,
  input  logic sync_i,
  output logic sdclk_o,
  output logic sdout_o,
  output logic sync_o
);

  assign sdclk_o = ser_en_i & (sclk_i ^ inv_clk_i);
  assign sync_o  = ser_en_i & (sync_i ^ inv_sync_i);
  assign sdout_o = ser_en_i & sdout_i;

endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master #(
  parameter int DATA_W    = 14,
  parameter int DIV_W     = 2,
  parameter int FAST_HALF = 2,
  parameter int SLOW_HALF = 4,
  parameter int SLOW_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en,
  input  logic              rd_during,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              inv_clk,
  input  logic              inv_sync,
  input  logic              conv_start,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_valid,
  output logic              res_ready,
  output logic              busy,
  output logic              sdclk,
  output logic              sdout,
  output logic              sync
);

  logic              launch, launch_fast;
  logic [DATA_W-1:0] launch_data;
  logic              frame_active, frame_done;
  logic              sclk_raw, sdout_raw, sync_raw;

  adc_conv_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .conv_start_i   (conv_start),
    .rd_during_i    (rd_during),
    .ser_en_i       (ser_en),
    .res_data_i     (res_data),
    .res_valid_i    (res_valid),
    .res_ready_o    (res_ready),
    .busy_o         (busy),
    .frame_active_i (frame_active),
    .frame_done_i   (frame_done),
    .launch_o       (launch),
    .launch_fast_o  (launch_fast),
    .launch_data_o  (launch_data)
  );

  adc_frame_shifter #(
    .DATA_W    (DATA_W),
    .DIV_W     (DIV_W),
    .FAST_HALF (FAST_HALF),
    .SLOW_HALF (SLOW_HALF),
    .SLOW_BITS (SLOW_BITS)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (launch),
    .fast_i   (launch_fast),
    .div_i    (div_sel),
    .data_i   (launch_data),
    .sclk_o   (sclk_raw),
    .sdout_o  (sdout_raw),
    .sync_o   (sync_raw),
    .active_o (frame_active),
    .done_o   (frame_done)
  );

  adc_pin_drive u_pins (
    .ser_en_i   (ser_en),
    .inv_clk_i  (inv_clk),
    .inv_sync_i (inv_sync),
    .sclk_i     (sclk_raw),
    .sdout_i    (sdout_raw),
    .sync_i     (sync_raw),
    .sdclk_o    (sdclk),
    .sdout_o    (sdout),
    .sync_o     (sync)
  );

endmodule

// File: tb/adc_serial_master_tb_top.sv
module adc_serial_master_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        ser_en = 1'b1, rd_during = 1'b1, inv_clk = 1'b0, inv_sync = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic        conv_start = 1'b0, res_valid = 1'b0;
  logic [13:0] res_data = '0;
  logic        res_ready, busy, sdclk, sdout, sync;

  adc_serial_master dut_i (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .rd_during(rd_during),
    .div_sel(div_sel), .inv_clk(inv_clk), .inv_sync(inv_sync),
    .conv_start(conv_start), .res_data(res_data), .res_valid(res_valid),
    .res_ready(res_ready), .busy(busy), .sdclk(sdclk), .sdout(sdout), .sync(sync)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- monitor (samples 2 ns after each falling edge)
  int frame_cnt = 0, last_word = 0, last_np = 0, last_sync = 0, last_lead = 0;
  int last_viol = 0, stray = 0, last_busy = 0, off_act = 0;
  int w = 0, np = 0, sl = 0, ld = 0, vi = 0, br = 0;
  int hi[14], last_hi[14];
  bit rc_p = 0, sr_p = 0, do_p = 0, bz_p = 0;

  always begin
    bit rc, sr;
    @(negedge clk); #2;
    rc = sdclk ^ inv_clk;
    sr = sync ^ inv_sync;
    if (sr && !sr_p) begin
      w = 0; np = 0; sl = 0; ld = 0; vi = 0;
      for (int i = 0; i < 14; i++) hi[i] = 0;
    end
    if (sr) begin
      sl++;
      if (np == 0 && !rc) ld++;
    end
    if (rc && !rc_p) begin
      w = (w << 1) | int'(sdout);
      if (np < 14) hi[np] = 1;
      np++;
    end else if (rc && rc_p) begin
      if (np >= 1 && np <= 14) hi[np-1]++;
      if (sdout != do_p) vi++;
    end
    if (rc && !sr) stray++;
    if (!sr && sr_p) begin
      last_word = w; last_np = np; last_sync = sl; last_lead = ld; last_viol = vi;
      last_hi = hi;
      frame_cnt++;
    end
    if (busy) begin
      if (!bz_p) br = 0;
      br++;
    end else if (bz_p) last_busy = br;
    if (!ser_en && (sdclk || sync || sdout)) off_act++;
    rc_p = rc; sr_p = sr; do_p = sdout; bz_p = busy;
  end

  // ---------------- helpers
  task automatic do_conv(input int wt, input logic [13:0] d, input bit poke);
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = poke;
    repeat (wt) begin @(negedge clk); conv_start = 1'b0; end
    res_valid = 1'b1; res_data = d;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    int n = 0;
    repeat (2) @(negedge clk);
    #2;
    while ((busy || (sync ^ inv_sync)) && n < 3000) begin
      @(negedge clk); #2; n++;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic int frame_len(input bit fast, input int div);
    return fast ? 74 : 2 + 28 * (2 << div);
  endfunction

  task automatic check_frame(input string rq, input int exp, input bit fast, input int div);
    int bad = 0;
    chk("R2 frame word", last_word, exp);
    chk("R2 pulse count", last_np, 14);
    chk("R2 stray clock pulses", stray, 0);
    chk("R3 data change during high phase", last_viol, 0);
    chk("R4 sync lead", last_lead, 1);
    chk("R4 sync length", last_sync, frame_len(fast, div));
    for (int i = 0; i < 14; i++) begin
      int e = fast ? ((i >= 10) ? 4 : 2) : (2 << div);
      if (last_hi[i] != e) bad++;
    end
    chk({rq, " half-period mismatches"}, bad, 0);
  endtask

  // ---------------- scenarios
  task automatic t_reset();
    #2;
    chk("R1 busy", int'(busy), 0);
    chk("R1 res_ready", int'(res_ready), 0);
    chk("R1 sdclk", int'(sdclk), 0);
    chk("R1 sync", int'(sync), 0);
    chk("R1 sdout", int'(sdout), 0);
  endtask

  task automatic t_first_no_frame();
    int fc = frame_cnt;
    rd_during = 1'b1;
    do_conv(2, 14'h1A5C, 0);
    wait_quiet();
    chk("R6 no frame after reset", frame_cnt - fc, 0);
    chk("R6 busy width", last_busy, 3);
  endtask

  task automatic t_during();
    int fc = frame_cnt;
    do_conv(2, 14'h2B3D, 0);
    wait_quiet();
    chk("R6 one frame", frame_cnt - fc, 1);
    chk("R6 busy width", last_busy, 3);
    check_frame("R7", 14'h1A5C, 1, 0);
  endtask

  task automatic t_polarity();
    @(negedge clk); inv_clk = 1'b1; inv_sync = 1'b1;
    @(negedge clk); #2;
    chk("R5 inverted sdclk idle", int'(sdclk), 1);
    chk("R5 inverted sync idle", int'(sync), 1);
    do_conv(3, 14'h0FF1, 0);
    wait_quiet();
    check_frame("R5", 14'h2B3D, 1, 0);
    @(negedge clk); inv_clk = 1'b0; inv_sync = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_ignore_in_frame();
    int fc = frame_cnt;
    rd_during = 1'b1;
    do_conv(1, 14'h3C3C, 0);
    repeat (4) @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    #2;
    chk("R10 busy after start during frame", int'(busy), 0);
    chk("R10 res_ready after start during frame", int'(res_ready), 0);
    wait_quiet();
    chk("R10 single frame", frame_cnt - fc, 1);
    check_frame("R10", 14'h0FF1, 1, 0);
  endtask

  task automatic t_ready();
    int fc = frame_cnt;
    @(negedge clk); res_valid = 1'b1; res_data = 14'h3FFF;
    repeat (2) @(negedge clk);
    #2;
    chk("R11 ready low when idle", int'(res_ready), 0);
    chk("R11 busy unaffected", int'(busy), 0);
    @(negedge clk); res_valid = 1'b0;
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    #2;
    chk("R11 ready while pending", int'(res_ready), 1);
    @(negedge clk); res_valid = 1'b1; res_data = 14'h0421;
    @(negedge clk); res_valid = 1'b0;
    #2;
    chk("R11 ready drops after take", int'(res_ready), 0);
    wait_quiet();
    chk("R11 frame count", frame_cnt - fc, 1);
    check_frame("R11", 14'h3C3C, 1, 0);
  endtask

  task automatic t_after(input int div, input bit ic, input bit is, input logic [13:0] d,
                         input int wt);
    int fc;
    @(negedge clk); rd_during = 1'b0; div_sel = 2'(div); inv_clk = ic; inv_sync = is;
    @(negedge clk);
    fc = frame_cnt;
    do_conv(wt, d, 0);
    wait_quiet();
    chk("R8 one frame", frame_cnt - fc, 1);
    chk("R8 busy width", last_busy, wt + 1 + frame_len(0, div));
    check_frame("R9", d, 0, div);
    @(negedge clk); inv_clk = 1'b0; inv_sync = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_ignore_busy();
    int fc;
    @(negedge clk); rd_during = 1'b0; div_sel = 2'd0;
    fc = frame_cnt;
    do_conv(3, 14'h1111, 1);
    wait_quiet();
    chk("R10 single frame while busy", frame_cnt - fc, 1);
    chk("R10 busy width", last_busy, 4 + 58);
    chk("R10 frame word", last_word, 14'h1111);
  endtask

  task automatic t_ser_off();
    int fc, oa;
    @(negedge clk); ser_en = 1'b0; rd_during = 1'b0;
    @(negedge clk);
    fc = frame_cnt; oa = off_act;
    do_conv(2, 14'h2222, 0);
    wait_quiet();
    chk("R12 no frame when disabled", frame_cnt - fc, 0);
    chk("R12 pins active when disabled", off_act - oa, 0);
    chk("R12 busy not stretched", last_busy, 3);
    @(negedge clk); ser_en = 1'b1; rd_during = 1'b1;
    @(negedge clk);
    fc = frame_cnt;
    do_conv(2, 14'h3333, 0);
    wait_quiet();
    chk("R12 frame after re-enable", frame_cnt - fc, 1);
    check_frame("R12", 14'h2222, 1, 0);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- main
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_no_frame();
    t_during();
    t_polarity();
    t_ignore_in_frame();
    t_ready();
    t_after(0, 0, 0, 14'h2A55, 1);
    t_after(1, 1, 0, 14'h1234, 4);
    t_after(2, 0, 1, 14'h3E07, 2);
    t_after(3, 1, 1, 14'h0C81, 3);
    t_ignore_busy();
    t_ser_off();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule